// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block keeps the per-channel control and status registers of a legacy bus-master DMA engine in a storage controller. There are two channels by default, primary and secondary, and each has a command byte, a status byte and a 32-bit descriptor-table base. Software reaches them through a simple register port. The port takes a word address, 32-bit write data, four byte enables and a write strobe, and it returns the addressed word on `reg_rdata` in the same cycle.

The DMA engine and the link layer report events to the block through single-cycle pulses, one bit per channel. The events are: a descriptor completed, the completed descriptor had its interrupt request set, an end-of-table region finished its last transfer, a device FIS arrived with its interrupt bit set, and a bus abort occurred. A level input gives the device-control interrupt-enable state. Toward the engine the block drives the Start bit, a one-cycle go pulse, and the table base of each channel. The block contains no data path. All control and status pins are plain levels or pulses, with no handshake.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset every status byte and command byte reads 00h, every table base reads 0, and `dma_start` and `dma_go` are low.
- R2: The channel c window begins at byte 8·c. The command byte is at offset +0, the status byte at +2, and the table base at +4..+7. Word address 2c returns {8'h0, status, 8'h0, command}. Word address 2c+1 returns the table base. Bytes 1 and 3 of the first word read 0 and ignore writes.
- R3: Status bit 7 sets one cycle after a pulse on `ev_prd_done` that arrives together with `ev_prd_irq`. It clears only when software writes 1 to it. A completion that arrives without the interrupt flag leaves the bit unchanged.
- R4: Status bit 2 sets one cycle after an `ev_fis_irq` pulse, but only while `dev_ien` is 1. The same pulse arriving while `dev_ien` is 0 leaves the bit at 0. The bit clears when software writes 1 to it.
- R5: Status bit 1 sets one cycle after an `ev_abort` pulse and clears when software writes 1 to it.
- R6: Status bit 5 is a plain read/write bit with no effect on the hardware. Status bits 6, 4 and 3 always read 0 and ignore writes.
- R7: Writing 1 to command bit 0 while status bit 0 is clear does three things: it sets status bit 0, it sets `dma_start`, and it raises `dma_go` for exactly one cycle. The go pulse appears in the cycle after the write. Writing 1 again while status bit 0 is set produces no go pulse and leaves the bit set.
- R8: Status bit 0 clears one cycle after an `ev_eot_done` pulse, or after a write of 0 to command bit 0. The end-of-table event leaves `dma_start` unchanged. The write of 0 also drops `dma_start`.
- R9: A hardware set event and a software write-1 clear that hit the same status bit in the same cycle leave the bit set.
- R10: Each byte of the table base is written only under its own byte enable. Bits 1:0 always read 0. `tbl_base` shows the stored value of each channel.
- R11: Writes and events aimed at one channel leave the registers of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_waddr | input | WA (2) | Word address; word 2c is command/status and word 2c+1 is the table base of channel c |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for the write |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data of the addressed word, combinational |
| ev_prd_done | input | NCH | Descriptor finished, per channel |
| ev_prd_irq | input | NCH | The finished descriptor requested an interrupt |
| ev_eot_done | input | NCH | Last transfer of the end-of-table region completed |
| ev_fis_irq | input | NCH | Device FIS received with its interrupt bit set |
| dev_ien | input | NCH | Device-control interrupt-enable state (level) |
| ev_abort | input | NCH | Target or master abort on the host bus |
| dma_start | output | NCH | Start bit of each channel |
| dma_go | output | NCH | One-cycle pulse when a channel becomes active |
| tbl_base | output | NCH*32 | Descriptor-table base, channel c in bits [32c+31:32c] |

## Verification
The bench writes Start twice in a row. A design that fires the go pulse on every Start write, rather than only on the inactive-to-active edge, would show a second pulse on `dma_go`. It drives a FIS interrupt pulse while the interrupt enable is low. A design that ignores the gate would set bit 2. It lines up a flag event with a write-1 clear of the same bit in the same cycle. A design that gives the clear priority would lose that event. Partial byte-enable writes to the table base, and traffic aimed at one channel, show up any byte that is written without its enable, any low pointer bit that leaks through, and any write decoded to the wrong channel.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int REG_W = 32;
  localparam int BYTES = REG_W / 8;

  // status bit positions (software decodes these)
  localparam int ST_PRD = 7;
  localparam int ST_CAP = 5;
  localparam int ST_FIS = 2;
  localparam int ST_ERR = 1;
  localparam int ST_ACT = 0;

  localparam int CMD_START = 0;

  // byte lanes inside the command/status word
  localparam int CMD_LANE = 0;
  localparam int STS_LANE = 2;

  // table base low bits forced to zero (dword alignment)
  localparam logic [REG_W-1:0] PTR_MASK = ~REG_W'(3);

  typedef struct packed {
    logic prd_done;
    logic prd_irq;
    logic eot_done;
    logic fis_irq;
    logic ien;
    logic abort;
  } chan_ev_t;
endpackage

// File: rtl/bmdma_w1c.sv
module bmdma_w1c (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  // a set event outranks a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_i | (flag_q & ~clr_i);
  end
endmodule

// File: rtl/bmdma_wdec.sv
module bmdma_wdec
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WA = SW + 1
) (
  input  logic [WA-1:0]        waddr,
  input  logic [BYTES-1:0]     be,
  input  logic                 wr,
  output logic [NCH-1:0]       cmd_we,
  output logic [NCH-1:0]       sts_we,
  output logic [NCH*BYTES-1:0] ptr_be
);
  logic [SW-1:0] sel;
  logic          is_ptr;

  assign sel    = waddr[WA-1:1];
  assign is_ptr = waddr[0];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit       = wr && (sel == SW'(c));
    assign cmd_we[c] = hit && !is_ptr && be[CMD_LANE];
    assign sts_we[c] = hit && !is_ptr && be[STS_LANE];
    assign ptr_be[c*BYTES +: BYTES] = (hit && is_ptr) ? be : '0;
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_wd,
  input  logic             sts_we,
  input  logic [7:0]       sts_wd,
  input  logic [BYTES-1:0] ptr_be,
  input  logic [REG_W-1:0] ptr_wd,
  input  chan_ev_t         ev,
  output logic [7:0]       cmd_q,
  output logic [7:0]       sts_q,
  output logic [REG_W-1:0] ptr_q,
  output logic             start_q,
  output logic             go_q
);
  logic act_q, cap_q, prd_q, fis_q, err_q;
  logic start_wr1, start_wr0;

  assign start_wr1 = cmd_we &&  cmd_wd[CMD_START];
  assign start_wr0 = cmd_we && !cmd_wd[CMD_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      act_q   <= 1'b0;
      go_q    <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      if (cmd_we) start_q <= cmd_wd[CMD_START];
      go_q <= start_wr1 && !act_q;
      if (start_wr1)                        act_q <= 1'b1;
      else if (start_wr0 || ev.eot_done)    act_q <= 1'b0;
      if (sts_we) cap_q <= sts_wd[ST_CAP];
    end
  end

  bmdma_w1c u_prd (
    .clk(clk), .rst_n(rst_n),
    .set_i(ev.prd_done && ev.prd_irq),
    .clr_i(sts_we && sts_wd[ST_PRD]),
    .flag_q(prd_q)
  );

  bmdma_w1c u_fis (
    .clk(clk), .rst_n(rst_n),
    .set_i(ev.fis_irq && ev.ien),
    .clr_i(sts_we && sts_wd[ST_FIS]),
    .flag_q(fis_q)
  );

  bmdma_w1c u_err (
    .clk(clk), .rst_n(rst_n),
    .set_i(ev.abort),
    .clr_i(sts_we && sts_wd[ST_ERR]),
    .flag_q(err_q)
  );

  always_comb begin
    sts_q         = '0;
    sts_q[ST_PRD] = prd_q;
    sts_q[ST_CAP] = cap_q;
    sts_q[ST_FIS] = fis_q;
    sts_q[ST_ERR] = err_q;
    sts_q[ST_ACT] = act_q;
    cmd_q            = '0;
    cmd_q[CMD_START] = start_q;
  end

  logic [REG_W-1:0] ptr_r;
  for (genvar b = 0; b < BYTES; b++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)        ptr_r[b*8 +: 8] <= '0;
      else if (ptr_be[b]) ptr_r[b*8 +: 8] <= ptr_wd[b*8 +: 8] & PTR_MASK[b*8 +: 8];
    end
  end
  assign ptr_q = ptr_r;
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int WA = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WA-1:0]        reg_waddr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic [BYTES-1:0]     reg_be,
  input  logic                 reg_wr,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]       ev_prd_done,
  input  logic [NCH-1:0]       ev_prd_irq,
  input  logic [NCH-1:0]       ev_eot_done,
  input  logic [NCH-1:0]       ev_fis_irq,
  input  logic [NCH-1:0]       dev_ien,
  input  logic [NCH-1:0]       ev_abort,
  output logic [NCH-1:0]       dma_start,
  output logic [NCH-1:0]       dma_go,
  output logic [NCH*REG_W-1:0] tbl_base
);
  logic [NCH-1:0]       cmd_we, sts_we;
  logic [NCH*BYTES-1:0] ptr_be;
  logic [7:0]           cmd_q [NCH];
  logic [7:0]           sts_q [NCH];
  logic [REG_W-1:0]     ptr_q [NCH];

  bmdma_wdec #(.NCH(NCH)) u_wdec (
    .waddr(reg_waddr), .be(reg_be), .wr(reg_wr),
    .cmd_we(cmd_we), .sts_we(sts_we), .ptr_be(ptr_be)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_ev_t ev;
    assign ev = '{prd_done: ev_prd_done[c], prd_irq: ev_prd_irq[c],
                  eot_done: ev_eot_done[c], fis_irq: ev_fis_irq[c],
                  ien: dev_ien[c], abort: ev_abort[c]};

    bmdma_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(cmd_we[c]), .cmd_wd(reg_wdata[CMD_LANE*8 +: 8]),
      .sts_we(sts_we[c]), .sts_wd(reg_wdata[STS_LANE*8 +: 8]),
      .ptr_be(ptr_be[c*BYTES +: BYTES]), .ptr_wd(reg_wdata),
      .ev(ev),
      .cmd_q(cmd_q[c]), .sts_q(sts_q[c]), .ptr_q(ptr_q[c]),
      .start_q(dma_start[c]), .go_q(dma_go[c])
    );
    assign tbl_base[c*REG_W +: REG_W] = ptr_q[c];
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (reg_waddr[WA-1:1] == SW'(c)) begin
        if (reg_waddr[0]) reg_rdata = ptr_q[c];
        else reg_rdata = (REG_W'(sts_q[c]) << (8*STS_LANE)) |
                         (REG_W'(cmd_q[c]) << (8*CMD_LANE));
      end
    end
  end
endmodule

// File: rtl/bmdma_chan_chk.sv
module bmdma_chan_chk
  import bmdma_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_wd,
  input chan_ev_t   ev,
  input logic [7:0] sts_q,
  input logic       go_q
);
  // R3
  prd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.prd_done && ev.prd_irq) |=> sts_q[ST_PRD]);

  // R4
  fis_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.fis_irq && ev.ien) |=> sts_q[ST_FIS]);

  // R4
  fis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.fis_irq && !ev.ien && !sts_q[ST_FIS]) |=> !sts_q[ST_FIS]);

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.abort |=> sts_q[ST_ERR]);

  // R7
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[ST_ACT]) |-> go_q);

  // R7
  go_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);

  // R8
  act_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.eot_done && !(cmd_we && cmd_wd[CMD_START])) |=> !sts_q[ST_ACT]);
endmodule

bind bmdma_chan bmdma_chan_chk u_chan_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wd(cmd_wd),
  .ev(ev), .sts_q(sts_q), .go_q(go_q)
);

// File: tb/tb_bmdma_regfile.sv
`timescale 1ns/1ps
module tb_bmdma_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_be;
  logic        reg_wr;
  logic [31:0] reg_rdata;
  logic [1:0]  ev_prd_done, ev_prd_irq, ev_eot_done, ev_fis_irq, dev_ien, ev_abort;
  logic [1:0]  dma_start, dma_go;
  logic [63:0] tbl_base;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bmdma_regfile #(.NCH(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
    .ev_prd_done(ev_prd_done), .ev_prd_irq(ev_prd_irq), .ev_eot_done(ev_eot_done),
    .ev_fis_irq(ev_fis_irq), .dev_ien(dev_ien), .ev_abort(ev_abort),
    .dma_start(dma_start), .dma_go(dma_go), .tbl_base(tbl_base)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int wa, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    reg_waddr = wa[1:0]; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(int wa, output logic [31:0] d);
    reg_waddr = wa[1:0];
    #1;
    d = reg_rdata;
  endtask

  // kind: 0 prd+irq, 1 prd only, 2 eot, 3 fis, 4 abort
  task automatic ev_pulse(int kind, int c);
    @(negedge clk);
    case (kind)
      0: begin ev_prd_done[c] = 1'b1; ev_prd_irq[c] = 1'b1; end
      1: ev_prd_done[c] = 1'b1;
      2: ev_eot_done[c] = 1'b1;
      3: ev_fis_irq[c] = 1'b1;
      default: ev_abort[c] = 1'b1;
    endcase
    @(negedge clk);
    ev_prd_done = '0; ev_prd_irq = '0; ev_eot_done = '0; ev_fis_irq = '0; ev_abort = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R1 ch0 cmd/status", d, 0);
    rd(1, d); chk("R1 ch0 base", d, 0);
    rd(2, d); chk("R1 ch1 cmd/status", d, 0);
    chk("R1 start/go", {dma_start, dma_go}, 0);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    wr(0, 32'hFFFF_FF00, 4'b1110);
    rd(0, d); chk("R6 R2 cap set, reserved and spare lanes zero", d, 32'h0020_0000);
    rd(2, d); chk("R11 ch1 untouched by cap write", d, 0);
    wr(0, 32'h0000_0000, 4'b0100);
    rd(0, d); chk("R6 cap cleared", d, 0);
  endtask

  task automatic t_prd();
    logic [31:0] d;
    ev_pulse(0, 0);
    rd(0, d); chk("R3 prd flag set", d[23:16], 8'h80);
    ev_pulse(1, 1);
    rd(2, d); chk("R3 completion without irq", d[23:16], 8'h00);
    wr(0, 32'h0000_0000, 4'b0100);
    rd(0, d); chk("R3 write 0 keeps flag", d[23:16], 8'h80);
    wr(0, 32'h0080_0000, 4'b0100);
    rd(0, d); chk("R3 w1c clears", d[23:16], 8'h00);
  endtask

  task automatic t_fis();
    logic [31:0] d;
    dev_ien = 2'b00;
    ev_pulse(3, 0);
    rd(0, d); chk("R4 gated by ien=0", d[23:16], 8'h00);
    dev_ien = 2'b01;
    ev_pulse(3, 0);
    rd(0, d); chk("R4 set with ien=1", d[23:16], 8'h04);
    wr(0, 32'h0004_0000, 4'b0100);
    rd(0, d); chk("R4 w1c clears", d[23:16], 8'h00);
    dev_ien = 2'b00;
  endtask

  task automatic t_abort();
    logic [31:0] d;
    ev_pulse(4, 1);
    rd(2, d); chk("R5 ch1 error set", d[23:16], 8'h02);
    rd(0, d); chk("R11 ch0 unaffected by ch1 abort", d, 0);
    wr(2, 32'h0002_0000, 4'b0100);
    rd(2, d); chk("R5 w1c clears", d[23:16], 8'h00);
  endtask

  task automatic t_start();
    logic [31:0] d;
    wr(0, 32'h1, 4'b0001);
    chk("R7 go pulse on first start", dma_go, 2'b01);
    rd(0, d); chk("R7 active and start set", d, 32'h0001_0001);
    chk("R8 dma_start follows start bit", dma_start, 2'b01);
    @(negedge clk);
    chk("R7 go lasts one cycle", dma_go, 2'b00);
    wr(0, 32'h1, 4'b0001);
    chk("R7 no second pulse while active", dma_go, 2'b00);
    rd(0, d); chk("R7 active stays set", d, 32'h0001_0001);
    ev_pulse(2, 0);
    rd(0, d); chk("R8 eot clears active, start kept", d, 32'h0000_0001);
    wr(0, 32'h1, 4'b0001);
    chk("R7 restart pulses again", dma_go, 2'b01);
    wr(0, 32'h0, 4'b0001);
    rd(0, d); chk("R8 start=0 clears active", d, 0);
    chk("R8 dma_start dropped", dma_start, 2'b00);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    ev_pulse(0, 1);
    @(negedge clk);
    reg_waddr = 2'd2; reg_wdata = 32'h0080_0000; reg_be = 4'b0100; reg_wr = 1'b1;
    ev_prd_done[1] = 1'b1; ev_prd_irq[1] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; ev_prd_done = '0; ev_prd_irq = '0;
    rd(2, d); chk("R9 set beats clear", d[23:16], 8'h80);
    wr(2, 32'h0080_0000, 4'b0100);
    rd(2, d); chk("R9 later clear works", d[23:16], 8'h00);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    wr(3, 32'h1234_5677, 4'b1111);
    rd(3, d); chk("R10 base low bits zero", d, 32'h1234_5674);
    chk("R10 tbl_base ch1", tbl_base[63:32], 32'h1234_5674);
    wr(3, 32'h0000_AB00, 4'b0010);
    rd(3, d); chk("R10 single byte enable", d, 32'h1234_AB74);
    rd(1, d); chk("R11 ch0 base untouched", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_be = '0; reg_wr = 1'b0;
    ev_prd_done = '0; ev_prd_irq = '0; ev_eot_done = '0; ev_fis_irq = '0;
    dev_ien = '0; ev_abort = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_prd();
    t_fis();
    t_abort();
    t_start();
    t_prio();
    t_ptr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule